// File: doc/BRIEF.md
# Package Sleep State Sequencer

This block tracks which package-level low-power state the processor package is in. Four active-low control lines form a ladder: stop-clock, sleep, deep-sleep and deeper-power-reduction. Each line moves the package one rung deeper when it is asserted and one rung back when it is released. The sequencer follows those lines, reports the current state, and says whether the package can take a snoop at that moment.

Snoops are only served from the Stop Grant rung, through a short side state that is left when the snoop completes. The deepest rung cannot take snoops. In that rung a snoop request or a break event raises a wake request, which stays up until the package is back in the Normal state. The return from Stop Grant to Normal waits until the memory side reports that its DLLs are awake and it has left self-refresh. A line change that skips a rung is ignored by the state and reported as a protocol error.

Top module: `pkg_sleep_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `state` is 0 (Normal), `snoop_ok` is 1, and `wake_req` and `proto_err` are 0. The state codes are 0 Normal, 1 Stop Grant, 2 Stop Grant Snoop, 3 Sleep, 4 Deep Sleep, 5 Deeper Sleep.
- R2: In Normal, `ctl_n[0]` (stop-clock) low at a clock edge moves `state` to 1 at that edge.
- R3: In Stop Grant, `snoop_req` high moves `state` to 2. This move takes priority over every other move out of Stop Grant. State 2 returns to 1 at the first edge where `snoop_done` is high.
- R4: Stop Grant moves to Sleep when `ctl_n[1]` is low. Sleep moves back to Stop Grant when `ctl_n[1]` is high.
- R5: Sleep moves to Deep Sleep when `ctl_n[2]` is low. Deep Sleep moves back to Sleep when `ctl_n[2]` is high.
- R6: Deep Sleep moves to Deeper Sleep when `ctl_n[3]` is low. Deeper Sleep moves back to Deep Sleep when `ctl_n[3]` is high.
- R7: Stop Grant returns to Normal only at an edge where `ctl_n[0]` is high, `mem_ready` is high and `snoop_req` is low. While `mem_ready` is low, the state stays at Stop Grant.
- R8: `snoop_ok` is 1 exactly when `state` is Normal or Stop Grant.
- R9: In Deeper Sleep, `snoop_req` or `break_evt` high at an edge sets `wake_req` after that edge, and the state does not change. `wake_req` then stays high until `state` reads Normal. It is 0 whenever `state` is Normal.
- R10: If, at an edge, any line `ctl_n[i]` (i from 1 to 3) is low while `ctl_n[i-1]` is high, `proto_err` is 1 for the following cycle. The skipped rung is not entered, and `snoop_req` in Sleep or Deep Sleep is ignored.
- R11: The state moves by at most one rung per clock edge, even when several lines change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_n | input | 4 | Active-low ladder lines: bit 0 stop-clock, bit 1 sleep, bit 2 deep-sleep, bit 3 deeper-power-reduction |
| mem_ready | input | 1 | Memory DLLs awake and out of self-refresh |
| snoop_req | input | 1 | Incoming snoop or snoopable event |
| snoop_done | input | 1 | The snoop in progress has been serviced |
| break_evt | input | 1 | Break event requesting a return to full power |
| state | output | 3 | Current package state code |
| snoop_ok | output | 1 | The package can accept a snoop now |
| wake_req | output | 1 | The core must be woken |
| proto_err | output | 1 | A rung-skipping line pattern was seen in the previous cycle |

## Verification
A wrong rung in the state register shows on `state` and usually on `snoop_ok` in the cycle right after the faulty edge. Because every later move depends on the current rung, the error then carries into every following transition. A lost or stuck wake flag shows on `wake_req` one edge after a Deeper Sleep snoop or break, or on the first cycle back in Normal. The bench compares all four outputs against a behavioural model after every edge, so the first wrong cycle is reported.

// File: rtl/pss_pkg.sv
package pss_pkg;

    localparam int unsigned N_LINES = 4;

    typedef enum logic [2:0] {
        PS_NORMAL  = 3'd0,
        PS_STOPGNT = 3'd1,
        PS_SGSNOOP = 3'd2,
        PS_SLEEP   = 3'd3,
        PS_DEEP    = 3'd4,
        PS_DEEPER  = 3'd5
    } pstate_e;

    localparam int unsigned STATE_W = $bits(pstate_e);

    typedef struct packed {
        logic [N_LINES-1:0] on;
        logic               skip;
    } ladder_t;

    function automatic logic snoop_allowed(input pstate_e s);
        return (s == PS_NORMAL) || (s == PS_STOPGNT);
    endfunction

endpackage

// File: rtl/pss_ladder_decode.sv
module pss_ladder_decode
    import pss_pkg::*;
(
    input  logic [N_LINES-1:0] ctl_n,
    output ladder_t            lad
);

    logic [N_LINES-1:0] bad;

    assign bad[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N_LINES; i++) begin : g_line
            assign lad.on[i] = ~ctl_n[i];
            if (i > 0) begin : g_pair
                // a deeper line is active while its shallower neighbour is not
                assign bad[i] = ~ctl_n[i] & ctl_n[i-1];
            end
        end
    endgenerate

    assign lad.skip = |bad;

endmodule

// File: rtl/pss_state_seq.sv
module pss_state_seq
    import pss_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] on,
    input  logic               mem_ready,
    input  logic               snoop_req,
    input  logic               snoop_done,
    output pstate_e            state_q
);

    pstate_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_NORMAL: begin
                if (on[0]) state_d = PS_STOPGNT;
            end
            PS_STOPGNT: begin
                if (snoop_req) begin
                    state_d = PS_SGSNOOP;
                end else if (!on[0]) begin
                    if (mem_ready) state_d = PS_NORMAL;
                end else if (on[1]) begin
                    state_d = PS_SLEEP;
                end
            end
            PS_SGSNOOP: begin
                if (snoop_done) state_d = PS_STOPGNT;
            end
            PS_SLEEP: begin
                if (!on[1])     state_d = PS_STOPGNT;
                else if (on[2]) state_d = PS_DEEP;
            end
            PS_DEEP: begin
                if (!on[2])     state_d = PS_SLEEP;
                else if (on[3]) state_d = PS_DEEPER;
            end
            PS_DEEPER: begin
                if (!on[3]) state_d = PS_DEEP;
            end
            default: state_d = PS_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_NORMAL;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/pss_wake_ctrl.sv
module pss_wake_ctrl
    import pss_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pstate_e state_q,
    input  logic    snoop_req,
    input  logic    break_evt,
    output logic    wake_req
);

    logic wake_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q <= 1'b0;
        end else if (state_q == PS_DEEPER && (snoop_req || break_evt)) begin
            wake_q <= 1'b1;
        end else if (state_q == PS_NORMAL) begin
            wake_q <= 1'b0;
        end
    end

    assign wake_req = wake_q && (state_q != PS_NORMAL);

endmodule

// File: rtl/pkg_sleep_seq.sv
module pkg_sleep_seq
    import pss_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] ctl_n,
    input  logic               mem_ready,
    input  logic               snoop_req,
    input  logic               snoop_done,
    input  logic               break_evt,
    output logic [STATE_W-1:0] state,
    output logic               snoop_ok,
    output logic               wake_req,
    output logic               proto_err
);

    ladder_t lad;
    pstate_e cur;
    logic    perr_q;

    pss_ladder_decode u_dec (
        .ctl_n (ctl_n),
        .lad   (lad)
    );

    pss_state_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .on         (lad.on),
        .mem_ready  (mem_ready),
        .snoop_req  (snoop_req),
        .snoop_done (snoop_done),
        .state_q    (cur)
    );

    pss_wake_ctrl u_wake (
        .clk       (clk),
        .rst       (rst),
        .state_q   (cur),
        .snoop_req (snoop_req),
        .break_evt (break_evt),
        .wake_req  (wake_req)
    );

    always_ff @(posedge clk) begin
        if (rst) perr_q <= 1'b0;
        else     perr_q <= lad.skip;
    end

    assign state     = cur;
    assign snoop_ok  = snoop_allowed(cur);
    assign proto_err = perr_q;

endmodule

// File: rtl/pss_checker.sv
module pss_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] ctl_n,
    input logic       mem_ready,
    input logic       snoop_req,
    input logic       break_evt,
    input logic [2:0] state,
    input logic       snoop_ok,
    input logic       wake_req,
    input logic       proto_err
);

    // R2
    normal_to_stopgnt_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd0 && !ctl_n[0]) |=> (state == 3'd1));

    // R7
    mem_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd1 && !mem_ready) |=> (state != 3'd0));

    // R8
    no_snoop_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        (state >= 3'd2) |-> !snoop_ok);

    // R9
    wake_set_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd5 && (snoop_req || break_evt)) |=> (wake_req && state == 3'd5));

    // R9
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> (wake_req || state == 3'd0));

    // R10
    skip_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_n[2] && ctl_n[1]) |=> proto_err);

    // R11
    one_rung_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd0) |=> (state == 3'd0 || state == 3'd1));

endmodule

bind pkg_sleep_seq pss_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .ctl_n     (ctl_n),
    .mem_ready (mem_ready),
    .snoop_req (snoop_req),
    .break_evt (break_evt),
    .state     (state),
    .snoop_ok  (snoop_ok),
    .wake_req  (wake_req),
    .proto_err (proto_err)
);

// File: tb/pkg_sleep_seq_tb_top.sv
module pkg_sleep_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ctl_n = 4'b1111;
    logic       mem_ready = 1'b1;
    logic       snoop_req = 1'b0;
    logic       snoop_done = 1'b0;
    logic       break_evt = 1'b0;
    logic [2:0] state;
    logic       snoop_ok, wake_req, proto_err;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;

    int    m_st = 0;
    bit    m_wake = 0;
    bit    m_perr = 0;
    string m_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pkg_sleep_seq dut_i (
        .clk(clk), .rst(rst), .ctl_n(ctl_n), .mem_ready(mem_ready),
        .snoop_req(snoop_req), .snoop_done(snoop_done), .break_evt(break_evt),
        .state(state), .snoop_ok(snoop_ok), .wake_req(wake_req), .proto_err(proto_err)
    );

    // behavioural reference, advanced on every edge
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_wake = 0; m_perr = 0; m_tag = "R1";
        end else begin
            m_perr = 0;
            for (int k = 1; k < 4; k++)
                if (ctl_n[k] == 1'b0 && ctl_n[k-1] == 1'b1) m_perr = 1;
            if (m_st == 5 && (snoop_req || break_evt)) m_wake = 1;
            else if (m_st == 0) m_wake = 0;
            m_tag = "R11";
            if (m_st == 0) begin
                if (!ctl_n[0]) begin m_st = 1; m_tag = "R2"; end
            end else if (m_st == 1) begin
                if (snoop_req) begin m_st = 2; m_tag = "R3"; end
                else if (ctl_n[0]) begin
                    m_tag = "R7";
                    if (mem_ready) m_st = 0;
                end else if (!ctl_n[1]) begin m_st = 3; m_tag = "R4"; end
            end else if (m_st == 2) begin
                if (snoop_done) begin m_st = 1; m_tag = "R3"; end
            end else if (m_st == 3) begin
                if (ctl_n[1]) begin m_st = 1; m_tag = "R4"; end
                else if (!ctl_n[2]) begin m_st = 4; m_tag = "R5"; end
            end else if (m_st == 4) begin
                if (ctl_n[2]) begin m_st = 3; m_tag = "R5"; end
                else if (!ctl_n[3]) begin m_st = 5; m_tag = "R6"; end
            end else begin
                if (ctl_n[3]) begin m_st = 4; m_tag = "R6"; end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(m_tag, state, m_st);
        chk("R8", snoop_ok, (m_st <= 1) ? 1 : 0);
        chk("R9", wake_req, (m_wake && m_st != 0) ? 1 : 0);
        chk("R10", proto_err, m_perr);
    endtask

    task automatic step(input logic [3:0] c, input logic mr, input logic s,
                        input logic d, input logic b);
        ctl_n = c; mem_ready = mr; snoop_req = s; snoop_done = d; break_evt = b;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", state, 0);
        chk("R1", snoop_ok, 1);
        chk("R1", wake_req, 0);
        chk("R1", proto_err, 0);
        rst = 1'b0;
        step(4'b1111, 1, 0, 0, 0);
        chk("R1", state, 0);

        // R2 stop-clock
        step(4'b1110, 1, 0, 0, 0);
        chk("R2", state, 1);
        // R3 snoop side state
        step(4'b1110, 1, 1, 0, 0);
        chk("R3", state, 2);
        step(4'b1110, 1, 0, 0, 0);
        chk("R3", state, 2);
        step(4'b1110, 1, 0, 1, 0);
        chk("R3", state, 1);
        // R7 memory not ready holds Stop Grant
        step(4'b1111, 0, 0, 0, 0);
        step(4'b1111, 0, 0, 0, 0);
        chk("R7", state, 1);
        step(4'b1111, 1, 0, 0, 0);
        chk("R7", state, 0);

        // R11 all lines at once: one rung per edge
        step(4'b0000, 1, 0, 0, 0);
        chk("R11", state, 1);
        step(4'b0000, 1, 0, 0, 0);
        chk("R4", state, 3);
        step(4'b0000, 1, 1, 0, 0);    // snoop in Sleep ignored
        chk("R10", state, 4);
        chk("R8", snoop_ok, 0);
        step(4'b0000, 1, 0, 0, 0);
        chk("R6", state, 5);
        // R9 snoop in Deeper raises wake
        step(4'b0000, 1, 1, 0, 0);
        chk("R9", wake_req, 1);
        chk("R9", state, 5);
        step(4'b0001, 1, 0, 0, 0);    // out-of-order release
        chk("R10", proto_err, 1);
        chk("R10", state, 5);
        step(4'b1000, 1, 0, 0, 0);
        chk("R6", state, 4);
        step(4'b1100, 1, 0, 0, 0);
        chk("R5", state, 3);
        step(4'b1110, 1, 0, 0, 0);
        chk("R4", state, 1);
        chk("R9", wake_req, 1);
        step(4'b1111, 1, 0, 0, 0);
        chk("R9", wake_req, 0);
        chk("R2", state, 0);

        // R10 skip from Normal
        step(4'b1011, 1, 0, 0, 0);
        chk("R10", state, 0);
        chk("R10", proto_err, 1);
        step(4'b1111, 1, 0, 0, 0);
        chk("R10", proto_err, 0);

        // R9 break path
        step(4'b0000, 1, 0, 0, 0);
        step(4'b0000, 1, 0, 0, 0);
        step(4'b0000, 1, 0, 0, 0);
        step(4'b0000, 1, 0, 0, 0);
        chk("R6", state, 5);
        step(4'b0000, 1, 0, 0, 1);
        chk("R9", wake_req, 1);
        step(4'b1000, 1, 0, 0, 0);
        step(4'b1100, 1, 0, 0, 0);
        step(4'b1110, 1, 1, 0, 0);    // snoop during return from Sleep: ignored
        chk("R4", state, 1);
        step(4'b1111, 0, 0, 0, 0);
        chk("R7", state, 1);
        chk("R9", wake_req, 1);
        step(4'b1111, 1, 0, 0, 0);
        chk("R9", wake_req, 0);

        for (int n = 0; n < 20; n++)
            step((n % 3 == 0) ? 4'b1110 : 4'b1111, n[0], n[2], n[1], 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule